// File: doc/BRIEF.md
# Software Interrupt Entry Sequencer

This block performs the multi-cycle control sequence that a small 8-bit processor core runs when it executes a software interrupt instruction. The core has a 16-bit program counter and a stack that grows toward lower addresses. On a one-cycle start request the block takes the current program counter, index register, accumulator, condition code register and stack pointer. It then stores the processor context through a byte-wide memory port. After that it fetches a two-byte interrupt vector and returns the new program counter.

The saved program counter is the incoming value plus one, so the return address points past the instruction. Five bytes are stored, one per cycle: the low byte of that address first, then its high byte, the index register, the accumulator, and the condition code register last. Each store goes to the current stack pointer, which then moves down by one. After the last store the interrupt mask bit is set in the returned condition code register. The vector is then read, high byte first. The whole operation spans nine clock cycles, counting the start cycle, and ends with a one-cycle done pulse. While the block is busy, the stack pointer, condition code and program counter outputs hold the intermediate values. The parent core uses these outputs after done.

Top module: `swi_seq`

## Requirements
- R1: The saved return address is the incoming program counter plus one, modulo 2^16 (0xFFFF becomes 0x0000).
- R2: In the five cycles after the start cycle, mem_we is high and mem_re is low. The stored bytes are, in order: return address bits 7:0, return address bits 15:8, index, accumulator, condition code. They go to addresses SP, SP-1, SP-2, SP-3 and SP-4.
- R3: Stack pointer arithmetic wraps modulo 2^16. After the sequence, sp_out equals the incoming SP minus five.
- R4: The stored condition code byte is the incoming value unchanged. After the sequence, ccr_out equals the incoming value with bit 3 (the interrupt mask) forced to 1, and the other seven bits are unchanged.
- R5: In the 7th cycle mem_re is high with mem_addr = VEC_ADDR (default 0xFFFC), and the byte read becomes pc_out bits 15:8. In the 8th cycle mem_re is high with mem_addr = VEC_ADDR+1, and that byte becomes pc_out bits 7:0.
- R6: Count the cycle in which start is high and the block is idle as cycle 1. done is high in cycle 9 only and low in the cycle after. mem_we and mem_re are never high together.
- R7: A start request while busy is high, including the cycle in which done is high, has no effect. The running sequence and its outputs are unchanged, and no new sequence begins after it.
- R8: While rst_n is low at a clock edge, the block returns to idle. After that edge busy, done, mem_we and mem_re are 0, and sp_out, ccr_out and pc_out are 0. This also holds when reset arrives in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin the sequence; sampled only when idle |
| pc_in | input | 16 | Program counter at the instruction |
| x_in | input | 8 | Index register |
| a_in | input | 8 | Accumulator |
| ccr_in | input | 8 | Condition code register |
| sp_in | input | 16 | Stack pointer |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe |
| mem_addr | output | 16 | Memory address for the current access |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read; valid in the cycle mem_re is high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Updated stack pointer |
| ccr_out | output | 8 | Updated condition code register |
| pc_out | output | 16 | Program counter loaded from the vector |

## Verification
The five stores are due in cycles 2 to 6 and the two vector reads in cycles 7 and 8. The done pulse and the final sp_out, ccr_out and pc_out values are due in cycle 9, and idle must be back in cycle 10. The bench raises start half a cycle before the sampling edge. It then moves one falling edge per cycle and checks each cycle's strobe, address and data only at that cycle's falling edge, never at a neighbouring one. Requests made during a run, and reset in mid-run, are checked against the same cycle schedule.

// File: rtl/swi_pkg.sv
// Package: shared state encoding and helpers for the software interrupt
// entry sequencer. Assumes a fixed push-then-vector order; the ordering of
// enum members is the order of the sequence.
package swi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_PCL,
        ST_PUSH_PCH,
        ST_PUSH_X,
        ST_PUSH_A,
        ST_PUSH_CCR,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_FIN
    } swi_state_e;

    // Successor of a state once the sequence is running.
    function automatic swi_state_e next_step(input swi_state_e s);
        case (s)
            ST_PUSH_PCL: return ST_PUSH_PCH;
            ST_PUSH_PCH: return ST_PUSH_X;
            ST_PUSH_X:   return ST_PUSH_A;
            ST_PUSH_A:   return ST_PUSH_CCR;
            ST_PUSH_CCR: return ST_VEC_HI;
            ST_VEC_HI:   return ST_VEC_LO;
            ST_VEC_LO:   return ST_FIN;
            default:     return ST_IDLE;
        endcase
    endfunction

    // True for the five stacking states.
    function automatic logic is_push(input swi_state_e s);
        return (s == ST_PUSH_PCL) || (s == ST_PUSH_PCH) || (s == ST_PUSH_X)
            || (s == ST_PUSH_A) || (s == ST_PUSH_CCR);
    endfunction

    // True for the two vector fetch states.
    function automatic logic is_vec(input swi_state_e s);
        return (s == ST_VEC_HI) || (s == ST_VEC_LO);
    endfunction

endpackage

// File: rtl/swi_fsm.sv
// Module: swi_fsm
// Step counter of the sequencer. Leaves idle on start, walks the nine-cycle
// order one state per clock and ignores start while not idle.
// Assumes: start is a level sampled at each rising edge.
module swi_fsm
    import swi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output swi_state_e state,
    output logic       accept,
    output logic       busy,
    output logic       done
);

    swi_state_e st_q;

    // Start is taken only from idle.
    assign accept = (st_q == ST_IDLE) && start;
    assign busy   = (st_q != ST_IDLE);
    assign done   = (st_q == ST_FIN);
    assign state  = st_q;

    // State register: idle until accepted, then one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else if (st_q == ST_IDLE) begin
            if (start) begin
                st_q <= ST_PUSH_PCL;
            end
        end else begin
            st_q <= next_step(st_q);
        end
    end

    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy) else $error("sequence stalled"); // R7
    AST_FIN_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (st_q == ST_IDLE)) else $error("start taken while finishing"); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && !start) |=> (st_q == ST_IDLE)) else $error("left idle"); // R6

endmodule

// File: rtl/swi_sp_unit.sv
// Module: swi_sp_unit
// Stack pointer register. Loads the incoming SP on accept and steps it down
// by one after each stacked byte, wrapping modulo 2^AW.
// Assumes: load and dec are never high together.
module swi_sp_unit #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] sp_in,
    input  logic          dec,
    output logic [AW-1:0] sp_q
);

    localparam logic [AW-1:0] ONE = AW'(1);

    // Stack pointer: capture, then post-decrement per push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (load) begin
            sp_q <= sp_in;
        end else if (dec) begin
            sp_q <= sp_q - ONE;
        end
    end

    AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (sp_q == $past(sp_q) - ONE)) else $error("sp step"); // R3
    AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !load) |=> $stable(sp_q)) else $error("sp moved"); // R3

endmodule

// File: rtl/swi_ctx_regs.sv
// Module: swi_ctx_regs
// Context registers: the return address (PC plus one), X, A and CCR are
// captured on accept. A mux picks the byte stored in each push state. The
// mask bit is set at the end of the CCR push, and the vector bytes are loaded
// into the PC.
// Assumes: rdata is valid in the vector fetch states.
module swi_ctx_regs
    import swi_pkg::*;
#(
    parameter int unsigned DW       = 8,
    parameter int unsigned MASK_BIT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  swi_state_e      state,
    input  logic [2*DW-1:0] pc_in,
    input  logic [DW-1:0]   x_in,
    input  logic [DW-1:0]   a_in,
    input  logic [DW-1:0]   ccr_in,
    input  logic [DW-1:0]   rdata,
    output logic [2*DW-1:0] pc_q,
    output logic [DW-1:0]   ccr_q,
    output logic [DW-1:0]   wdata
);

    localparam int unsigned AW   = 2 * DW;
    localparam logic [DW-1:0] MBIT = DW'(1) << MASK_BIT;

    logic [DW-1:0] x_q;
    logic [DW-1:0] a_q;

    // Capture context and return address; later load the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            x_q  <= '0;
            a_q  <= '0;
        end else if (load) begin
            pc_q <= pc_in + AW'(1);
            x_q  <= x_in;
            a_q  <= a_in;
        end else if (state == ST_VEC_HI) begin
            pc_q[AW-1:DW] <= rdata;
        end else if (state == ST_VEC_LO) begin
            pc_q[DW-1:0] <= rdata;
        end
    end

    // Condition code: capture, then set the mask once it has been stacked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccr_q <= '0;
        end else if (load) begin
            ccr_q <= ccr_in;
        end else if (state == ST_PUSH_CCR) begin
            ccr_q <= ccr_q | MBIT;
        end
    end

    // Byte to store in the current push state.
    always_comb begin
        case (state)
            ST_PUSH_PCL: wdata = pc_q[DW-1:0];
            ST_PUSH_PCH: wdata = pc_q[AW-1:DW];
            ST_PUSH_X:   wdata = x_q;
            ST_PUSH_A:   wdata = a_q;
            ST_PUSH_CCR: wdata = ccr_q;
            default:     wdata = '0;
        endcase
    end

    AST_MASK_AFTER_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_CCR) |=> (ccr_q[MASK_BIT]
            && ((ccr_q | MBIT) == ($past(ccr_q) | MBIT)))) else $error("mask set"); // R4
    AST_CCR_STILL_IN_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (is_push(state) && !load) |=> (is_push(state) ? $stable(ccr_q) : 1'b1))
        else $error("ccr changed before stacked"); // R4
    AST_PC_HELD_IN_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (is_push(state) && (state != ST_PUSH_CCR)) |=> $stable(pc_q))
        else $error("pc changed while stacking"); // R1

endmodule

// File: rtl/swi_seq.sv
// Module: swi_seq (top)
// Software interrupt entry sequencer. It stacks the return address, X, A
// and CCR through a byte port (five cycles), reads the two-byte vector (two
// cycles) and pulses done in the ninth cycle.
// Assumes: memory reads return data in the same cycle mem_re is high.
module swi_seq
    import swi_pkg::*;
#(
    parameter int unsigned DW       = 8,
    parameter int unsigned VEC_ADDR = 'hFFFC,
    parameter int unsigned MASK_BIT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2*DW-1:0] pc_in,
    input  logic [DW-1:0]   x_in,
    input  logic [DW-1:0]   a_in,
    input  logic [DW-1:0]   ccr_in,
    input  logic [2*DW-1:0] sp_in,
    output logic            mem_we,
    output logic            mem_re,
    output logic [2*DW-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            done,
    output logic [2*DW-1:0] sp_out,
    output logic [DW-1:0]   ccr_out,
    output logic [2*DW-1:0] pc_out
);

    localparam int unsigned AW = 2 * DW;
    localparam logic [AW-1:0] VEC_HI_A = AW'(VEC_ADDR);
    localparam logic [AW-1:0] VEC_LO_A = AW'(VEC_ADDR + 1);

    swi_state_e state;
    logic       accept;
    logic       push;

    swi_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .state  (state),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    assign push = is_push(state);

    swi_sp_unit #(.AW(AW)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .sp_in (sp_in),
        .dec   (push),
        .sp_q  (sp_out)
    );

    swi_ctx_regs #(.DW(DW), .MASK_BIT(MASK_BIT)) u_ctx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .state  (state),
        .pc_in  (pc_in),
        .x_in   (x_in),
        .a_in   (a_in),
        .ccr_in (ccr_in),
        .rdata  (mem_rdata),
        .pc_q   (pc_out),
        .ccr_q  (ccr_out),
        .wdata  (mem_wdata)
    );

    // Memory strobes and address: stack pointer while pushing, vector after.
    always_comb begin
        mem_we = push;
        mem_re = is_vec(state);
        case (state)
            ST_VEC_HI: mem_addr = VEC_HI_A;
            ST_VEC_LO: mem_addr = VEC_LO_A;
            default:   mem_addr = push ? sp_out : '0;
        endcase
    end

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)) else $error("read and write together"); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R6
    AST_DONE_AFTER_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(mem_re) && (mem_addr == '0))) else $error("done early"); // R5
    AST_PUSH_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_we) && mem_we) |-> (mem_addr == $past(mem_addr) - AW'(1)))
        else $error("push address step"); // R2

endmodule

// File: tb/swi_seq_tb.sv
// Bench for swi_seq: a table of cases walked by one loop, then directed
// tests for requests while busy and for reset in mid-sequence.
module swi_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  x_in = '0;
    logic [7:0]  a_in = '0;
    logic [7:0]  ccr_in = '0;
    logic [15:0] sp_in = '0;
    logic        mem_we, mem_re, busy, done;
    logic [15:0] mem_addr, sp_out, pc_out;
    logic [7:0]  mem_wdata, mem_rdata, ccr_out;
    logic [7:0]  vh = 8'h00;
    logic [7:0]  vl = 8'h00;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // Memory model: vector bytes at 0xFFFC/0xFFFD, filler elsewhere.
    assign mem_rdata = (mem_addr == 16'hFFFC) ? vh :
                       (mem_addr == 16'hFFFD) ? vl : 8'hEE;

    swi_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .ccr_in(ccr_in), .sp_in(sp_in),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .sp_out(sp_out), .ccr_out(ccr_out), .pc_out(pc_out)
    );

    // Fields: pc[71:56] x[55:48] a[47:40] ccr[39:32] sp[31:16] vh[15:8] vl[7:0]
    localparam logic [71:0] CASES [4] = '{
        {16'h1234, 8'h56, 8'h78, 8'hC0, 16'h00FF, 8'hE0, 8'h10},
        {16'hFFFF, 8'hA5, 8'h5A, 8'h08, 16'h0001, 8'h80, 8'h00},
        {16'h00FF, 8'h01, 8'hFE, 8'hF7, 16'h0000, 8'h3C, 8'hC3},
        {16'hABCD, 8'h00, 8'hFF, 8'h00, 16'h1000, 8'h12, 8'h34}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Run one sequence; inject_at >= 0 raises a foreign start in that step.
    task automatic run_case(input logic [71:0] v, input int inject_at);
        logic [15:0] ret;
        logic [15:0] sp0;
        logic [7:0]  bytes [5];
        ret = v[71:56] + 16'd1;
        sp0 = v[31:16];
        bytes[0] = ret[7:0];
        bytes[1] = ret[15:8];
        bytes[2] = v[55:48];
        bytes[3] = v[47:40];
        bytes[4] = v[39:32];
        vh = v[15:8];
        vl = v[7:0];
        pc_in = v[71:56]; x_in = v[55:48]; a_in = v[47:40];
        ccr_in = v[39:32]; sp_in = v[31:16];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i == inject_at) begin
                start = 1'b1;
                pc_in = 16'h5555; sp_in = 16'h7777; ccr_in = 8'h11;
            end else begin
                start = 1'b0;
            end
            if (i < 5) begin
                chk("R2 we", {31'd0, mem_we}, 32'd1);
                chk("R6 re low", {31'd0, mem_re}, 32'd0);
                chk("R3 push addr", {16'd0, mem_addr}, {16'd0, sp0 - 16'(i)});
                chk((i < 2) ? "R1 ret byte" : (i == 4) ? "R4 stacked ccr" : "R2 data",
                    {24'd0, mem_wdata}, {24'd0, bytes[i]});
            end else if (i < 7) begin
                chk("R5 re", {30'd0, mem_re, mem_we}, 32'd2);
                chk("R5 vec addr", {16'd0, mem_addr}, (i == 5) ? 32'hFFFC : 32'hFFFD);
                chk("R6 no early done", {31'd0, done}, 32'd0);
            end else begin
                chk("R6 done", {31'd0, done}, 32'd1);
                chk("R3 sp_out", {16'd0, sp_out}, {16'd0, sp0 - 16'd5});
                chk("R4 ccr_out", {24'd0, ccr_out}, {24'd0, v[39:32] | 8'h08});
                chk("R5 pc_out", {16'd0, pc_out}, {16'd0, v[15:8], v[7:0]});
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R6 done drops", {31'd0, done}, 32'd0);
        chk("R7 no restart", {29'd0, busy, mem_we, mem_re}, 32'd0);
        chk("R7 outputs kept", {pc_out, sp_out}, {v[15:8], v[7:0], sp0 - 16'd5});
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset strobes", {28'd0, busy, done, mem_we, mem_re}, 32'd0);
        chk("R8 reset regs", {sp_out, pc_out}, 32'd0);
        chk("R8 reset ccr", {24'd0, ccr_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 idle without start", {30'd0, busy, mem_we}, 32'd0);

        for (int k = 0; k < 4; k++) begin
            run_case(CASES[k], -1);
            @(negedge clk);
        end

        // R7: foreign request mid-stack and in the done cycle.
        run_case(CASES[0], 2);
        @(negedge clk);
        run_case(CASES[3], 7);
        @(negedge clk);

        // R8: reset in the middle of a sequence.
        pc_in = 16'h2000; sp_in = 16'h0400; ccr_in = 8'h00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 mid reset idle", {28'd0, busy, done, mem_we, mem_re}, 32'd0);
        chk("R8 mid reset regs", {sp_out, pc_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 stays idle", {31'd0, busy}, 32'd0);
        run_case(CASES[1], -1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule